// File: doc/BRIEF.md
# Trap and Subroutine Control-Transfer Unit

This block is the slice of a 16-bit processor's execute stage that carries out the four control-transfer instructions that leave a trail back to the caller: the system-call trap, the PC-relative subroutine call, the register-based subroutine call, and the register jump, including the return form that jumps through R7. It receives the instruction word, the program counter that fetch has already incremented, and one read port of the register file. It produces a PC load and a link write of the return address into R7.

Calls and jumps resolve in the cycle they are issued. The register file read is combinational, and the link write lands on the next clock edge. A trap is an indirect jump. The unit zero-extends the 8-bit vector into a word address in the table that occupies the lowest 256 words of memory. It then raises a read request and holds it until the memory returns a valid word. In that same cycle, the returned word goes to the PC and the return address captured at issue goes to R7. While the table read is outstanding the unit reports busy and takes no new instruction.

Top module: `ctl_xfer_unit`

## Requirements
- R1: The opcode is IR[15:12] and 1111 is a trap. When a trap issues while the unit is idle, `mem_req` is high from the next cycle on. `mem_addr` equals {8'h00, IR[7:0]}. Both hold unchanged until a cycle in which `mem_valid` is high.
- R2: In the cycle `mem_valid` is high during an outstanding trap read, `pc_load` and `link_we` are both high. `pc_next` equals `mem_rdata`. `link_data` equals the `pc_inc` value present at trap issue, even if `pc_inc` has changed since. In the following cycle `busy` and `mem_req` are low.
- R3: Opcode 0100 with IR[11]=1 is a relative call. In the issue cycle `pc_load` is high and `pc_next` equals `pc_inc` plus IR[10:0] sign-extended to 16 bits, wrapping modulo 2^16. `link_we` is high with `link_data` equal to `pc_inc`.
- R4: Opcode 0100 with IR[11]=0 is a register call. `rf_raddr` equals IR[8:6]. In the issue cycle `pc_next` equals the register read data, and `pc_load` and `link_we` are high with `link_data` equal to `pc_inc`.
- R5: Opcode 1100 is a register jump. `rf_raddr` equals IR[8:6], and `pc_next` equals the register read data with `pc_load` high and `link_we` low. With IR[8:6]=7 it is the return.
- R6: A register call whose base is R7 jumps to the value R7 held before the call's own link write.
- R7: While `busy` is high, an asserted `issue` has no effect: `pc_load` and `link_we` stay low except in the `mem_valid` cycle, and the trap address does not change.
- R8: Any other opcode leaves `pc_load`, `link_we` and `mem_req` low.
- R9: After reset `busy`, `mem_req`, `pc_load` and `link_we` are low. A `mem_valid` pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction in `ir` is presented for execution this cycle |
| ir | input | 16 | Instruction word |
| pc_inc | input | 16 | Already-incremented program counter |
| rf_raddr | output | 3 | Register file read address (base register) |
| rf_rdata | input | 16 | Register file read data for `rf_raddr` |
| mem_req | output | 1 | Trap table read request |
| mem_addr | output | 16 | Trap table word address |
| mem_valid | input | 1 | Table read data valid |
| mem_rdata | input | 16 | Table read data (service routine address) |
| busy | output | 1 | Trap table read outstanding |
| pc_load | output | 1 | Load `pc_next` into the PC at the clock edge |
| pc_next | output | 16 | New PC value |
| link_we | output | 1 | Write `link_data` into R7 at the clock edge |
| link_data | output | 16 | Return address |

## Verification
The hardest case to reach is a trap whose table read stays open for several cycles while other traffic keeps arriving. The stimulus has to keep `issue` high with a call encoding and change `pc_inc` during that wait. It then has to check both that nothing commits early and that the committed return address is the one captured at issue. The bench drives the memory model with a random latency of zero to four cycles. It optionally injects such stray issues and always scrambles `pc_inc` before raising `mem_valid`. The R7-based register call is reached by running a trap or a call first, so that R7 holds a known return address. A register call through R7 then issues, and its target is compared with that earlier value, not the new link.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam logic [3:0] OPC_CALL = 4'b0100;
  localparam logic [3:0] OPC_JUMP = 4'b1100;
  localparam logic [3:0] OPC_TRAP = 4'b1111;

  typedef enum logic {ST_IDLE, ST_WAIT} trap_st_e;

  typedef struct packed {
    logic is_trap;
    logic is_call;
    logic is_jump;
    logic rel_mode;
  } op_class_t;
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
#(
  parameter int XLEN   = 16,
  parameter int OFF_W  = 11,
  parameter int REG_AW = 3,
  parameter int VEC_W  = 8
) (
  input  logic [XLEN-1:0]   ir,
  input  logic [XLEN-1:0]   pc_inc,
  input  logic [XLEN-1:0]   rf_rdata,
  output op_class_t         cls,
  output logic [REG_AW-1:0] rf_raddr,
  output logic [XLEN-1:0]   target,
  output logic [VEC_W-1:0]  vec
);
  localparam int OPC_LSB  = XLEN - 4;
  localparam int BASE_LSB = 6;
  localparam int MODE_BIT = OFF_W;

  logic [3:0]      opc;
  logic [XLEN-1:0] offset_ext;

  always_comb begin
    opc          = ir[OPC_LSB +: 4];
    cls.is_trap  = (opc == OPC_TRAP);
    cls.is_call  = (opc == OPC_CALL);
    cls.is_jump  = (opc == OPC_JUMP);
    cls.rel_mode = cls.is_call & ir[MODE_BIT];
    rf_raddr     = ir[BASE_LSB +: REG_AW];
    vec          = ir[VEC_W-1:0];
    offset_ext   = {{(XLEN-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};
    target       = cls.rel_mode ? (pc_inc + offset_ext) : rf_rdata;
  end
endmodule

// File: rtl/xfer_trap_fsm.sv
module xfer_trap_fsm
  import xfer_pkg::*;
#(
  parameter int XLEN  = 16,
  parameter int VEC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VEC_W-1:0] vec,
  input  logic [XLEN-1:0] pc_inc,
  input  logic            mem_valid,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] saved_pc
);
  trap_st_e         st_q, st_d;
  logic [VEC_W-1:0] vec_q;
  logic [XLEN-1:0]  pc_q;
  logic             capture;

  always_comb begin
    st_d    = st_q;
    capture = 1'b0;
    done    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d    = ST_WAIT;
        capture = 1'b1;
      end
      ST_WAIT: if (mem_valid) begin
        st_d = ST_IDLE;
        done = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      pc_q  <= '0;
    end else if (capture) begin
      vec_q <= vec;
      pc_q  <= pc_inc;
    end
  end

  always_comb begin
    busy     = (st_q == ST_WAIT);
    mem_req  = busy;
    mem_addr = {{(XLEN-VEC_W){1'b0}}, vec_q};
    saved_pc = pc_q;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req); // R1
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> $stable(mem_addr)); // R7
  AST_RELEASE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_valid |=> !mem_req); // R2
endmodule

// File: rtl/ctl_xfer_unit.sv
module ctl_xfer_unit
  import xfer_pkg::*;
#(
  parameter int XLEN   = 16,
  parameter int OFF_W  = 11,
  parameter int REG_AW = 3,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [XLEN-1:0]   ir,
  input  logic [XLEN-1:0]   pc_inc,
  output logic [REG_AW-1:0] rf_raddr,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              mem_req,
  output logic [XLEN-1:0]   mem_addr,
  input  logic              mem_valid,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              busy,
  output logic              pc_load,
  output logic [XLEN-1:0]   pc_next,
  output logic              link_we,
  output logic [XLEN-1:0]   link_data
);
  op_class_t        cls;
  logic [XLEN-1:0]  target;
  logic [VEC_W-1:0] vec;
  logic             accept;
  logic             trap_start;
  logic             trap_done;
  logic [XLEN-1:0]  saved_pc;

  xfer_decode #(.XLEN(XLEN), .OFF_W(OFF_W), .REG_AW(REG_AW), .VEC_W(VEC_W)) u_dec (
    .ir       (ir),
    .pc_inc   (pc_inc),
    .rf_rdata (rf_rdata),
    .cls      (cls),
    .rf_raddr (rf_raddr),
    .target   (target),
    .vec      (vec)
  );

  always_comb begin
    accept     = issue & ~busy;
    trap_start = accept & cls.is_trap;
  end

  xfer_trap_fsm #(.XLEN(XLEN), .VEC_W(VEC_W)) u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (trap_start),
    .vec       (vec),
    .pc_inc    (pc_inc),
    .mem_valid (mem_valid),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .done      (trap_done),
    .saved_pc  (saved_pc)
  );

  always_comb begin
    pc_load   = 1'b0;
    link_we   = 1'b0;
    pc_next   = target;
    link_data = pc_inc;
    if (trap_done) begin
      pc_load   = 1'b1;
      link_we   = 1'b1;
      pc_next   = mem_rdata;
      link_data = saved_pc;
    end else if (accept & (cls.is_call | cls.is_jump)) begin
      pc_load = 1'b1;
      link_we = cls.is_call;
    end
  end

  AST_TRAP_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_valid |-> pc_load && link_we && (pc_next == mem_rdata)); // R2
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_valid |-> !pc_load && !link_we); // R7
  AST_LINK_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> pc_load); // R3
  AST_IDLE_VALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !issue && mem_valid |=> !busy); // R9
  AST_REQ_AFTER_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && issue && (ir[XLEN-1 -: 4] == OPC_TRAP) |=> mem_req); // R1
endmodule

// File: tb/ctl_xfer_unit_tb.sv
module ctl_xfer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [15:0] ir, pc_inc, rf_rdata, mem_addr, mem_rdata, pc_next, link_data;
  logic [2:0]  rf_raddr;
  logic        mem_req, mem_valid, busy, pc_load, link_we;
  logic [15:0] regs [8];
  int          n_checks = 0;
  int          n_errors = 0;

  always #5 clk = ~clk;

  ctl_xfer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .ir(ir), .pc_inc(pc_inc),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .busy(busy), .pc_load(pc_load), .pc_next(pc_next), .link_we(link_we),
    .link_data(link_data)
  );

  assign rf_rdata = regs[rf_raddr];

  always_ff @(posedge clk) if (link_we) regs[7] <= link_data;

  function automatic logic [15:0] tbl(input logic [15:0] a);
    return 16'hA000 ^ (a * 16'h0137);
  endfunction

  function automatic logic [15:0] sext11(input logic [10:0] v);
    return {{5{v[10]}}, v};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_instr(input logic [15:0] ir_v, input logic [15:0] pc_v,
                           input int wait_c, input bit stray);
    logic [3:0]  opc;
    logic [15:0] base;
    opc  = ir_v[15:12];
    base = regs[ir_v[8:6]];
    @(negedge clk);
    issue = 1'b1; ir = ir_v; pc_inc = pc_v;
    #1;
    if (opc == 4'b1111) begin
      chk("R1", "pc_load at trap issue", {15'd0, pc_load}, 16'd0);
      @(negedge clk);
      issue = 1'b0; ir = 16'h0000; pc_inc = 16'($urandom);
      #1;
      chk("R1", "mem_req", {15'd0, mem_req}, 16'd1);
      chk("R1", "mem_addr", mem_addr, {8'h00, ir_v[7:0]});
      for (int k = 0; k < wait_c; k++) begin
        @(negedge clk);
        if (stray) begin
          issue = 1'b1;
          ir = {4'b0100, 1'b1, 11'($urandom)};
          pc_inc = 16'($urandom);
        end
        #1;
        chk("R7", "pc_load while busy", {15'd0, pc_load}, 16'd0);
        chk("R7", "link_we while busy", {15'd0, link_we}, 16'd0);
        chk("R7", "mem_addr while busy", mem_addr, {8'h00, ir_v[7:0]});
      end
      @(negedge clk);
      issue = stray; mem_valid = 1'b1; mem_rdata = tbl({8'h00, ir_v[7:0]});
      pc_inc = pc_v ^ 16'h5A5A;
      #1;
      chk("R2", "pc_load", {15'd0, pc_load}, 16'd1);
      chk("R2", "pc_next", pc_next, tbl({8'h00, ir_v[7:0]}));
      chk("R2", "link_we", {15'd0, link_we}, 16'd1);
      chk("R2", "link_data", link_data, pc_v);
      @(negedge clk);
      issue = 1'b0; mem_valid = 1'b0;
      #1;
      chk("R2", "busy after commit", {15'd0, busy}, 16'd0);
      chk("R2", "mem_req after commit", {15'd0, mem_req}, 16'd0);
    end else if (opc == 4'b0100) begin
      if (ir_v[11]) begin
        chk("R3", "pc_load", {15'd0, pc_load}, 16'd1);
        chk("R3", "pc_next", pc_next, pc_v + sext11(ir_v[10:0]));
        chk("R3", "link_we", {15'd0, link_we}, 16'd1);
        chk("R3", "link_data", link_data, pc_v);
      end else begin
        chk("R4", "rf_raddr", {13'd0, rf_raddr}, {13'd0, ir_v[8:6]});
        chk("R4", "pc_next", pc_next, base);
        chk("R4", "pc_load", {15'd0, pc_load}, 16'd1);
        chk("R4", "link_we", {15'd0, link_we}, 16'd1);
        chk("R4", "link_data", link_data, pc_v);
      end
      @(negedge clk); issue = 1'b0;
    end else if (opc == 4'b1100) begin
      chk("R5", "pc_next", pc_next, base);
      chk("R5", "pc_load", {15'd0, pc_load}, 16'd1);
      chk("R5", "link_we", {15'd0, link_we}, 16'd0);
      @(negedge clk); issue = 1'b0;
    end else begin
      chk("R8", "pc_load", {15'd0, pc_load}, 16'd0);
      chk("R8", "link_we", {15'd0, link_we}, 16'd0);
      @(negedge clk); issue = 1'b0;
      #1;
      chk("R8", "mem_req", {15'd0, mem_req}, 16'd0);
    end
  endtask

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [15:0] r7_old;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) regs[i] = 16'h1000 * 16'(i) + 16'h0011;
    rst_n = 1'b0; issue = 1'b0; ir = '0; pc_inc = '0; mem_valid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "busy in reset", {15'd0, busy}, 16'd0);
    chk("R9", "mem_req in reset", {15'd0, mem_req}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R9", "pc_load after reset", {15'd0, pc_load}, 16'd0);
    chk("R9", "link_we after reset", {15'd0, link_we}, 16'd0);
    // R9: stray valid while idle
    mem_valid = 1'b1; mem_rdata = 16'hDEAD; #1;
    chk("R9", "pc_load on idle valid", {15'd0, pc_load}, 16'd0);
    @(negedge clk); mem_valid = 1'b0; #1;
    chk("R9", "busy after idle valid", {15'd0, busy}, 16'd0);
    // directed corners
    run_instr({4'b0100, 1'b1, 11'h3FF}, 16'h3000, 0, 0);   // R3 max positive
    run_instr({4'b0100, 1'b1, 11'h400}, 16'h0100, 0, 0);   // R3 most negative, wraps
    run_instr({4'b0100, 1'b0, 2'b00, 3'd3, 6'd0}, 16'h3005, 0, 0); // R4 base R3
    run_instr({4'b1111, 4'h0, 8'h00}, 16'h3010, 0, 0);     // R1 vector 0, immediate valid
    run_instr({4'b1111, 4'h0, 8'hFF}, 16'h3020, 3, 1);     // R7 stray issues
    r7_old = regs[7];
    chk("R6", "R7 holds trap return", r7_old, 16'h3020);
    run_instr({4'b0100, 1'b0, 2'b00, 3'd7, 6'd0}, 16'h4444, 0, 0); // R6 JSRR R7
    run_instr({4'b1100, 3'b000, 3'd7, 6'd0}, 16'h5000, 0, 0);      // R5 return
    chk("R6", "R7 after JSRR R7", regs[7], 16'h4444);
    run_instr({4'b1100, 3'b000, 3'd2, 6'd0}, 16'h5002, 0, 0);      // R5 JMP R2
    run_instr(16'h1234, 16'h5004, 0, 0);                            // R8 other opcode
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [15:0] iv;
      int sel;
      sel = int'($urandom % 5);
      iv = 16'($urandom);
      case (sel)
        0: iv[15:12] = 4'b1111;
        1: iv[15:12] = 4'b0100;
        2: iv[15:12] = 4'b1100;
        3: iv[15:12] = 4'b0100;
        default: if (iv[15:12] inside {4'b1111, 4'b0100, 4'b1100}) iv[15:12] = 4'b0001;
      endcase
      if (sel == 0 || sel == 2) for (int b = 0; b < 1; b++) regs[int'($urandom % 7)] = 16'($urandom);
      run_instr(iv, 16'($urandom), int'($urandom % 5), 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule